// File: doc/BRIEF.md
# Multi-core grouped interrupt combiner

This block sits between an Ethernet MAC with its management (MDIO) unit and a set of processor cores. Each core owns one 32-bit enable word. The block masks the single-cycle event pulses coming from the MAC and MDIO with each core's enable word. For every core it then merges the surviving pulses into three separate interrupt pulses: one for the common (management and host) events, one for the transmit channels and one for the receive channels.

Software programs the enable words through a small write/read port. A core-select index picks the word to access. Unused bit positions in each word are kept at zero. After reset every source is masked. Each core enables only the channels it services, so several cores can share one MAC without taking each other's interrupts.

Top module: `mac_irq_fanout`

## Requirements
- R1: After a synchronous reset every enable word reads back as zero and all interrupt outputs are low.
- R2: Enable-word layout: bit 1 enables common source 0 (host), bit 2 common source 1 (statistics), bit 3 common source 2 (link change), bit 4 common source 3 (user management access), bits 15:8 transmit channels 7..0 (channel 0 at bit 8), bits 23:16 receive channels 7..0 (channel 0 at bit 16). Bits 31:24, 7:5 and 0 ignore writes and always read as zero.
- R3: A write to the word of core `cfg_sel` is stored at that clock edge and gates pulses from the next edge on. Pulses sampled at the write edge still use the old word. The other cores' words are not changed.
- R4: `irq_common[c]` is high in the cycle after an edge where any `src_common[i]` was high while core c's enable bit i+1 was set, and low otherwise.
- R5: `irq_tx[c]` is high in the cycle after an edge where any `src_tx[k]` was high while core c's bit 8+k was set, and low otherwise.
- R6: `irq_rx[c]` is high in the cycle after an edge where any `src_rx[k]` was high while core c's bit 16+k was set, and low otherwise.
- R7: Outputs are pulses. Several enabled sources of one group that pulse in the same cycle give one single-cycle pulse on that group's output. The output returns low in the next cycle if no enabled source is high.
- R8: A core-select value of N_CORES or more ignores writes and reads back zero.
- R9: `cfg_rdata` shows, one cycle later, the word that the selected core held just before the edge where the select was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the selected enable word |
| cfg_sel | input | 3 | Core select for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered readback of the selected word |
| src_common | input | 4 | Common event pulses: host, statistics, link change, user access |
| src_tx | input | 8 | Transmit channel pulses |
| src_rx | input | 8 | Receive channel pulses |
| irq_common | output | 6 | Per-core common interrupt pulse |
| irq_tx | output | 6 | Per-core transmit interrupt pulse |
| irq_rx | output | 6 | Per-core receive interrupt pulse |

## Verification
Every result of this block is due exactly one clock after its cause. Interrupt pulses follow the edge where the sources were sampled, readback follows the edge where the select was sampled, and a new enable word first gates pulses at the edge after its write. The bench drives all inputs at the falling edge. Before the rising edge it computes the expected outputs from its own model of the enable words as they were before that edge. It compares all outputs shortly after the edge, and only then applies the write to the model. Directed steps cover writes to reserved bits, the old-word behaviour on the write edge, isolation between cores, simultaneous pulses and out-of-range selects. A long random phase follows.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;
  localparam int REG_W   = 32;
  localparam int CHAN_N  = 8;
  localparam int COM_N   = 4;
  localparam int COM_LSB = 1;
  localparam int TX_LSB  = 8;
  localparam int RX_LSB  = 16;

  localparam logic [REG_W-1:0] COM_FIELD = ((REG_W'(1) << COM_N) - REG_W'(1)) << COM_LSB;
  localparam logic [REG_W-1:0] TX_FIELD  = ((REG_W'(1) << CHAN_N) - REG_W'(1)) << TX_LSB;
  localparam logic [REG_W-1:0] RX_FIELD  = ((REG_W'(1) << CHAN_N) - REG_W'(1)) << RX_LSB;
  localparam logic [REG_W-1:0] DEF_MASK  = COM_FIELD | TX_FIELD | RX_FIELD;

  typedef struct packed {
    logic [COM_N-1:0]  com;
    logic [CHAN_N-1:0] tx;
    logic [CHAN_N-1:0] rx;
  } enable_fields_t;

  function automatic enable_fields_t split_word(input logic [REG_W-1:0] w);
    enable_fields_t f;
    f.com = w[COM_LSB +: COM_N];
    f.tx  = w[TX_LSB +: CHAN_N];
    f.rx  = w[RX_LSB +: CHAN_N];
    return f;
  endfunction
endpackage

// File: rtl/irqfan_enable_bank.sv
module irqfan_enable_bank
  import irqfan_pkg::*;
#(
  parameter int N_CORES = 6,
  parameter int SEL_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  output logic [N_CORES*REG_W-1:0]   en_flat
);
  localparam logic [SEL_W:0] CORES_L = (SEL_W+1)'(N_CORES);

  logic [REG_W-1:0] word_q [N_CORES];
  logic [REG_W-1:0] rd_next;
  logic             sel_oob;

  assign sel_oob = ({1'b0, cfg_sel} >= CORES_L);

  for (genvar c = 0; c < N_CORES; c++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[c] <= '0;
      else if (cfg_wr && cfg_sel == SEL_W'(c))
        word_q[c] <= cfg_wdata & DEF_MASK;
    end
    assign en_flat[c*REG_W +: REG_W] = word_q[c];

    // R3: only the selected word moves on a write
    assert_other_cores_R3: assert property (@(posedge clk) disable iff (rst)
      (!cfg_wr || cfg_sel != SEL_W'(c)) |=> $stable(word_q[c]));
    // R3: the written value lands, minus reserved bits
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && cfg_sel == SEL_W'(c)) |=> (word_q[c] == ($past(cfg_wdata) & DEF_MASK)));
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < N_CORES; c++)
      if (cfg_sel == SEL_W'(c)) rd_next = word_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  // R2: reserved positions never show up at the port
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~DEF_MASK) == '0);
  // R8: an out-of-range select reads zero
  assert_oob_read_R8: assert property (@(posedge clk) disable iff (rst)
    sel_oob |=> (cfg_rdata == '0));
endmodule

// File: rtl/irqfan_core_merge.sv
module irqfan_core_merge
  import irqfan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  en_word,
  input  logic [COM_N-1:0]  src_com,
  input  logic [CHAN_N-1:0] src_tx,
  input  logic [CHAN_N-1:0] src_rx,
  output logic              irq_com,
  output logic              irq_tx,
  output logic              irq_rx
);
  enable_fields_t f;
  logic hit_com, hit_tx, hit_rx;

  assign f       = split_word(en_word);
  assign hit_com = |(src_com & f.com);
  assign hit_tx  = |(src_tx & f.tx);
  assign hit_rx  = |(src_rx & f.rx);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_com <= 1'b0;
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
    end else begin
      irq_com <= hit_com;
      irq_tx  <= hit_tx;
      irq_rx  <= hit_rx;
    end
  end

  // R4: a common pulse needs an enabled, active common source one cycle earlier
  assert_com_cause_R4: assert property (@(posedge clk) disable iff (rst)
    irq_com |-> $past(|(src_com & en_word[COM_LSB +: COM_N])));
  // R5: a transmit pulse needs an enabled, active transmit source one cycle earlier
  assert_tx_cause_R5: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(|(src_tx & en_word[TX_LSB +: CHAN_N])));
  // R6: a receive pulse needs an enabled, active receive source one cycle earlier
  assert_rx_cause_R6: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(|(src_rx & en_word[RX_LSB +: CHAN_N])));
  // R7: quiet sources give a low output on the next cycle
  assert_quiet_low_R7: assert property (@(posedge clk) disable iff (rst)
    (src_com == '0 && src_tx == '0 && src_rx == '0) |=> !(irq_com || irq_tx || irq_rx));
endmodule

// File: rtl/mac_irq_fanout.sv
module mac_irq_fanout
  import irqfan_pkg::*;
#(
  parameter int N_CORES = 6,
  localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES + 1) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic [COM_N-1:0]   src_common,
  input  logic [CHAN_N-1:0]  src_tx,
  input  logic [CHAN_N-1:0]  src_rx,
  output logic [N_CORES-1:0] irq_common,
  output logic [N_CORES-1:0] irq_tx,
  output logic [N_CORES-1:0] irq_rx
);
  logic [N_CORES*REG_W-1:0] en_flat;

  irqfan_enable_bank #(.N_CORES(N_CORES), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .en_flat   (en_flat)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    irqfan_core_merge u_merge (
      .clk     (clk),
      .rst     (rst),
      .en_word (en_flat[c*REG_W +: REG_W]),
      .src_com (src_common),
      .src_tx  (src_tx),
      .src_rx  (src_rx),
      .irq_com (irq_common[c]),
      .irq_tx  (irq_tx[c]),
      .irq_rx  (irq_rx[c])
    );
  end

  // R1: outputs are low in the first cycle after reset is released
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (irq_common == '0 && irq_tx == '0 && irq_rx == '0 && cfg_rdata == '0));
endmodule

// File: tb/tb_mac_irq_fanout.sv
`timescale 1ns/1ps
module tb_mac_irq_fanout;
  localparam int NC = 6;
  localparam logic [31:0] DEFB = 32'h00FF_FF1E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  src_common = '0;
  logic [7:0]  src_tx = '0, src_rx = '0;
  logic [NC-1:0] irq_common, irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [NC];

  always #2 clk = ~clk;

  mac_irq_fanout dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_common(src_common), .src_tx(src_tx), .src_rx(src_rx),
    .irq_common(irq_common), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, predict, compare after the rising edge, then update the model.
  task automatic step(input string tag, input bit wr, input logic [2:0] sel, input logic [31:0] wd,
                      input logic [3:0] com, input logic [7:0] tx, input logic [7:0] rx);
    logic [NC-1:0] e_com, e_tx, e_rx;
    logic [31:0] e_rd;
    @(negedge clk);
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    src_common = com; src_tx = tx; src_rx = rx;
    for (int c = 0; c < NC; c++) begin
      e_com[c] = 1'b0; e_tx[c] = 1'b0; e_rx[c] = 1'b0;
      for (int i = 0; i < 4; i++) if (com[i] && model[c][1+i]) e_com[c] = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (tx[k] && model[c][8+k])  e_tx[c] = 1'b1;
        if (rx[k] && model[c][16+k]) e_rx[c] = 1'b1;
      end
    end
    e_rd = (sel < NC) ? model[sel] : 32'h0;
    @(posedge clk);
    #1;
    check32(tag, "irq_common", 32'(irq_common), 32'(e_com));
    check32(tag, "irq_tx", 32'(irq_tx), 32'(e_tx));
    check32(tag, "irq_rx", 32'(irq_rx), 32'(e_rx));
    check32(tag, "cfg_rdata", cfg_rdata, e_rd);
    if (wr && sel < NC) model[sel] = wd & DEFB;
  endtask

  task automatic idle(input string tag, input logic [2:0] sel);
    step(tag, 1'b0, sel, 32'h0, 4'h0, 8'h0, 8'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) model[c] = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of every word and every output, with all sources pulsing
    for (int c = 0; c < NC; c++) step("R1", 1'b0, 3'(c), 32'h0, 4'hF, 8'hFF, 8'hFF);

    // R2: reserved bits ignore writes, defined fields are stored
    step("R2", 1'b1, 3'd0, 32'hFFFF_FFFF, 4'h0, 8'h0, 8'h0);
    idle("R2", 3'd0);                                   // expect 00FFFF1E
    step("R2", 1'b1, 3'd0, 32'hFF00_00E1, 4'h0, 8'h0, 8'h0);
    idle("R2", 3'd0);                                   // expect 0

    // R9: readback shows the value before the edge where the select was sampled
    step("R9", 1'b1, 3'd1, 32'h0000_0100, 4'h0, 8'h0, 8'h0);
    step("R9", 1'b1, 3'd1, 32'h0001_0000, 4'h0, 8'h0, 8'h0);
    idle("R9", 3'd1);

    // R3: pulse on the write edge uses the old word; other cores untouched
    step("R3", 1'b1, 3'd2, 32'h0000_0100, 4'h0, 8'h01, 8'h0);
    step("R3", 1'b0, 3'd2, 32'h0, 4'h0, 8'h01, 8'h0);
    idle("R3", 3'd3);

    // R4: host enabled on core 3; statistics pulse is masked, host pulse passes
    step("R4", 1'b1, 3'd3, 32'h0000_0002, 4'h0, 8'h0, 8'h0);
    step("R4", 1'b0, 3'd3, 32'h0, 4'h2, 8'h0, 8'h0);
    step("R4", 1'b0, 3'd3, 32'h0, 4'h1, 8'h0, 8'h0);
    step("R4", 1'b1, 3'd3, 32'h0000_0010, 4'h8, 8'h0, 8'h0);
    step("R4", 1'b0, 3'd3, 32'h0, 4'h8, 8'h0, 8'h0);

    // R5: transmit channel 7 only on core 5
    step("R5", 1'b1, 3'd5, 32'h0000_8000, 4'h0, 8'h0, 8'h0);
    step("R5", 1'b0, 3'd5, 32'h0, 4'h0, 8'h7F, 8'h80);
    step("R5", 1'b0, 3'd5, 32'h0, 4'h0, 8'h80, 8'h0);

    // R6: receive channel 0 only on core 4
    step("R6", 1'b1, 3'd4, 32'h0001_0000, 4'h0, 8'h0, 8'h0);
    step("R6", 1'b0, 3'd4, 32'h0, 4'h0, 8'h01, 8'hFE);
    step("R6", 1'b0, 3'd4, 32'h0, 4'h0, 8'h0, 8'h01);

    // R7: everything enabled, all sources at once, then quiet
    step("R7", 1'b1, 3'd4, 32'hFFFF_FFFF, 4'h0, 8'h0, 8'h0);
    step("R7", 1'b0, 3'd4, 32'h0, 4'hF, 8'hFF, 8'hFF);
    idle("R7", 3'd4);
    idle("R7", 3'd4);

    // R8: out-of-range selects ignore writes and read zero
    step("R8", 1'b1, 3'd6, 32'hFFFF_FFFF, 4'h0, 8'h0, 8'h0);
    step("R8", 1'b1, 3'd7, 32'hFFFF_FFFF, 4'h0, 8'h0, 8'h0);
    idle("R8", 3'd7);
    step("R8", 1'b0, 3'd6, 32'h0, 4'hF, 8'hFF, 8'hFF);
    for (int c = 0; c < NC; c++) idle("R8", 3'(c));

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit wr;
      logic [3:0] com;
      logic [7:0] tx, rx;
      wr  = ($urandom_range(0, 5) == 0);
      com = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      tx  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h0;
      rx  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h0;
      step("RND", wr, 3'($urandom_range(0, 7)), $urandom, com, tx, rx);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule